// File: doc/BRIEF.md
# Ratio-Coded System Clock Divider

This block takes one fast source clock and produces four clock-enable strobes: one each for the processor, a high-speed bus, a low-speed bus and the memory subsystem. Each strobe is high for one source cycle out of every N, where N comes from a 4-bit ratio code. Ratios follow a fixed non-power-of-two ladder: 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32. Logic downstream runs on the source clock and qualifies its registers with the strobe. The block does not build derived clocks.

All four ratio codes sit in one 32-bit control word, together with a change-enable flag. Software writes the whole word through a simple write port and can read it back. A new set of codes is loaded only at an alignment cycle, when every divider counter is at its terminal count at the same time, and only if the change-enable flag is set in the stored word at that moment. All counters then restart together. No strobe ever sees a shortened period, and the four strobes stay phase-aligned.

Top module: `sysclk_ratio_div`

## Requirements
- R1: Ratio codes 0, 1, 2, 3, 4, 5, 6, 7, 8 and 9 select division by 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32. The strobe is high for one cycle in every N cycles. With N = 1 it stays high continuously.
- R2: Any ratio code from 10 to 15 divides by 32.
- R3: In the control word, the processor code sits in bits [3:0], the high-speed bus code in [7:4], the low-speed bus code in [11:8] and the memory code in [15:12]. Bit 22 is the change-enable flag.
- R4: `rd_data` returns the full 32-bit word last written, starting in the cycle after the write edge. Its reset value is 0x0000_1110: processor code 0, the other codes 1, change-enable 0.
- R5: Out of reset, the processor strobe divides by 1 and the other three divide by 2. All four strobes are high in the first cycle after reset.
- R6: While the stored change-enable bit is 0, writes change only the readback. The active ratios keep their previous values.
- R7: The stored codes become active only at a cycle where all four strobes are high together and the stored change-enable bit is 1. Every counter restarts there, so each strobe next fires exactly its new ratio in cycles later, in step with the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Full control word to store |
| rd_data | output | 32 | Readback of the stored control word |
| tick_cpu | output | 1 | Processor clock-enable strobe |
| tick_hsb | output | 1 | High-speed bus clock-enable strobe |
| tick_lsb | output | 1 | Low-speed bus clock-enable strobe |
| tick_mem | output | 1 | Memory clock-enable strobe |

## Verification
The assertions assume that `wr_en` and `wr_data` are known values, synchronous to `clk`, and that reset is released between clock edges. The stimulus drives every input from the falling edge, so it always meets these assumptions. The random writes use fully random 32-bit words, including the unused bits and the saturating codes, and random gaps between writes. This places writes both before and inside alignment cycles, with change-enable set and cleared.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;

    localparam int unsigned SD_NUM_CH  = 4;
    localparam int unsigned SD_CODE_W  = 4;
    localparam int unsigned SD_CNT_W   = 5;
    localparam int unsigned SD_DATA_W  = 32;
    localparam int unsigned SD_CHG_BIT = 22;
    localparam logic [SD_DATA_W-1:0] SD_RESET_WORD = 32'h0000_1110;

    // Channel order equals field order in the control word
    typedef enum logic [1:0] {
        CH_CPU = 2'd0,
        CH_HSB = 2'd1,
        CH_LSB = 2'd2,
        CH_MEM = 2'd3
    } sd_chan_e;

    // Terminal count (ratio minus one) for a ratio code
    function automatic logic [SD_CNT_W-1:0] sd_term(input logic [SD_CODE_W-1:0] code);
        logic [SD_CNT_W-1:0] t;
        case (code)
            4'd0:    t = 5'd0;
            4'd1:    t = 5'd1;
            4'd2:    t = 5'd2;
            4'd3:    t = 5'd3;
            4'd4:    t = 5'd5;
            4'd5:    t = 5'd7;
            4'd6:    t = 5'd11;
            4'd7:    t = 5'd15;
            4'd8:    t = 5'd23;
            default: t = 5'd31;
        endcase
        return t;
    endfunction

    function automatic logic [SD_CODE_W-1:0] sd_field(input logic [SD_DATA_W-1:0] w,
                                                      input int unsigned idx);
        return w[idx*SD_CODE_W +: SD_CODE_W];
    endfunction

endpackage

// File: rtl/sysdiv_ctrl_reg.sv
module sysdiv_ctrl_reg
    import sysdiv_pkg::*;
#(
    parameter int unsigned DATA_W = SD_DATA_W,
    parameter logic [DATA_W-1:0] RESET_WORD = SD_RESET_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RESET_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

    AST_READBACK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (word == $past(wr_data))); // R4

    AST_READBACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word)); // R4

endmodule

// File: rtl/sysdiv_ratio_lut.sv
module sysdiv_ratio_lut
    import sysdiv_pkg::*;
#(
    parameter int unsigned CODE_W = SD_CODE_W,
    parameter int unsigned CNT_W  = SD_CNT_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  term
);

    always_comb begin
        term = CNT_W'(sd_term(SD_CODE_W'(code)));
    end

endmodule

// File: rtl/sysdiv_chan.sv
module sysdiv_chan #(
    parameter int unsigned CNT_W = 5,
    parameter logic [CNT_W-1:0] RST_CNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] term,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chan_st_t;

    chan_st_t st_d, st_q;

    assign tick = (st_q.cnt == term);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RST_CNT;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= term); // R1

endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
    import sysdiv_pkg::*;
#(
    parameter int unsigned NUM_CH  = SD_NUM_CH,
    parameter int unsigned CODE_W  = SD_CODE_W,
    parameter int unsigned CNT_W   = SD_CNT_W,
    parameter int unsigned DATA_W  = SD_DATA_W,
    parameter int unsigned CHG_BIT = SD_CHG_BIT,
    parameter logic [DATA_W-1:0] RESET_WORD = SD_RESET_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick_cpu,
    output logic              tick_hsb,
    output logic              tick_lsb,
    output logic              tick_mem
);

    localparam int unsigned CODES_W = NUM_CH * CODE_W;
    localparam logic [CODES_W-1:0] RST_CODES = RESET_WORD[CODES_W-1:0];

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] act;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [DATA_W-1:0]            ctrl_word;
    logic [NUM_CH-1:0][CNT_W-1:0] term;
    logic [NUM_CH-1:0]            tick_vec;
    logic                         align;
    logic                         chg_en;

    sysdiv_ctrl_reg #(
        .DATA_W     (DATA_W),
        .RESET_WORD (RESET_WORD)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word    (ctrl_word)
    );

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        sysdiv_ratio_lut #(
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W)
        ) u_lut (
            .code (st_q.act[gi]),
            .term (term[gi])
        );

        sysdiv_chan #(
            .CNT_W   (CNT_W),
            .RST_CNT (CNT_W'(sd_term(sd_field(RESET_WORD, gi))))
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .term  (term[gi]),
            .tick  (tick_vec[gi])
        );
    end

    assign align  = &tick_vec;
    assign chg_en = ctrl_word[CHG_BIT];

    always_comb begin
        st_d = st_q;
        if (align && chg_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                st_d.act[i] = ctrl_word[i*CODE_W +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act <= RST_CODES;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = ctrl_word;
    assign tick_cpu = tick_vec[CH_CPU];
    assign tick_hsb = tick_vec[CH_HSB];
    assign tick_lsb = tick_vec[CH_LSB];
    assign tick_mem = tick_vec[CH_MEM];

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_en |=> $stable(st_q.act)); // R6

    AST_LOAD_AT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.act) |-> $past(align && chg_en)); // R7

endmodule

// File: tb/test_sysclk_ratio_div.sv
`timescale 1ns/1ps
module test_sysclk_ratio_div;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_cpu, tick_hsb, tick_lsb, tick_mem;

    always #4 clk = ~clk;

    sysclk_ratio_div i_sysclk_ratio_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .tick_cpu (tick_cpu),
        .tick_hsb (tick_hsb),
        .tick_lsb (tick_lsb),
        .tick_mem (tick_mem)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          m_cnt [4];
    int          m_act [4];
    logic [31:0] m_ctrl;
    logic [3:0]  obs;

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            5: return 8;
            6: return 12;
            7: return 16;
            8: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [3:0] dut_ticks();
        return {tick_mem, tick_lsb, tick_hsb, tick_cpu};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint actual, input longint expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    task automatic compare_all();
        for (int ch = 0; ch < 4; ch++) begin
            bit e;
            e = (m_cnt[ch] == ratio_of(m_act[ch]) - 1);
            chk(obs[ch] == e, "R7", $sformatf("strobe ch%0d", ch), obs[ch], e);
        end
        chk(rd_data == m_ctrl, "R4", "readback", rd_data, m_ctrl);
    endtask

    task automatic model_adv(input bit we, input logic [31:0] wd);
        bit tk [4];
        bit al;
        al = 1'b1;
        for (int ch = 0; ch < 4; ch++) begin
            tk[ch] = (m_cnt[ch] == ratio_of(m_act[ch]) - 1);
            al = al & tk[ch];
        end
        if (al && m_ctrl[22]) begin
            for (int ch = 0; ch < 4; ch++) m_act[ch] = int'(m_ctrl[ch*4 +: 4]);
        end
        for (int ch = 0; ch < 4; ch++) m_cnt[ch] = tk[ch] ? 0 : m_cnt[ch] + 1;
        if (we) m_ctrl = wd;
    endtask

    task automatic step(input bit we, input logic [31:0] wd);
        wr_en   = we;
        wr_data = wd;
        model_adv(we, wd);
        @(negedge clk);
        obs = dut_ticks();
        compare_all();
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 32'h0);
    endtask

    // Count strobes of each channel over a 96-cycle window (multiple of every ratio)
    task automatic expect_counts(input string tag, input int e0, input int e1,
                                 input int e2, input int e3);
        int c [4];
        int e [4];
        e = '{e0, e1, e2, e3};
        c = '{0, 0, 0, 0};
        for (int k = 0; k < 96; k++) begin
            step(1'b0, 32'h0);
            for (int ch = 0; ch < 4; ch++) c[ch] += int'(obs[ch]);
        end
        for (int ch = 0; ch < 4; ch++)
            chk(c[ch] == e[ch], tag, $sformatf("strobe count ch%0d", ch), c[ch], e[ch]);
    endtask

    initial begin
        logic [31:0] w;
        int first [4];
        int t;
        m_ctrl = 32'h0000_1110;
        m_act  = '{0, 1, 1, 1};
        m_cnt  = '{0, 1, 1, 1};
        repeat (3) @(negedge clk);
        obs = dut_ticks();
        chk(obs == 4'hF, "R5", "strobes at reset", obs, 4'hF);
        chk(rd_data == 32'h0000_1110, "R4", "reset word", rd_data, 32'h0000_1110);
        rst_n = 1'b1;

        // R5: reset ratios 1,2,2,2
        expect_counts("R5", 96, 48, 48, 48);

        // R6: write with change-enable clear leaves ratios untouched
        w = 32'h0000_2359;
        step(1'b1, w);
        chk(rd_data == w, "R4", "readback after write", rd_data, w);
        idle(150);
        expect_counts("R6", 96, 48, 48, 48);

        // R3 / R1: set change-enable, cpu=9 hsb=5 lsb=3 mem=2
        step(1'b1, rd_data | 32'h0040_0000);
        idle(100);
        expect_counts("R3", 3, 12, 24, 32);

        // R1: cpu=4 hsb=6 lsb=7 mem=8
        step(1'b1, 32'h0040_8764);
        idle(100);
        expect_counts("R1", 16, 8, 6, 4);

        // R1: cpu=0 hsb=1 lsb=0 mem=1
        step(1'b1, 32'h0040_1010);
        idle(100);
        expect_counts("R1", 96, 48, 96, 48);

        // R2: saturating codes
        step(1'b1, 32'h0040_FCAB);
        idle(100);
        expect_counts("R2", 3, 3, 3, 3);

        // R7: after the alignment cycle each strobe first fires at its new ratio
        step(1'b1, 32'h0040_2345);
        t = 0;
        while (obs != 4'hF && t < 40) begin
            step(1'b0, 32'h0);
            t++;
        end
        chk(obs == 4'hF, "R7", "alignment reached", obs, 4'hF);
        first = '{0, 0, 0, 0};
        for (int k = 1; k <= 40; k++) begin
            step(1'b0, 32'h0);
            for (int ch = 0; ch < 4; ch++)
                if (obs[ch] && first[ch] == 0) first[ch] = k;
        end
        chk(first[0] == 8, "R7", "first cpu strobe", first[0], 8);
        chk(first[1] == 6, "R7", "first hsb strobe", first[1], 6);
        chk(first[2] == 4, "R7", "first lsb strobe", first[2], 4);
        chk(first[3] == 3, "R7", "first mem strobe", first[3], 3);

        // Random writes against the model
        void'($urandom(32'd7321));
        for (int n = 0; n < 60; n++) begin
            idle(int'($urandom_range(1, 120)));
            w = $urandom;
            if ($urandom_range(0, 1) == 1) w[22] = 1'b1;
            step(1'b1, w);
        end
        idle(200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule